// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block takes a received Reed-Solomon codeword over GF(2^8) one 8-bit symbol per clock and computes its 2t syndromes. The field is built from the primitive polynomial x^8+x^4+x^3+x^2+1, and the first root exponent is zero. With the default t=8 the block delivers sixteen syndromes, S0 to S15. Syndrome Si is the received polynomial evaluated at alpha^i.

Sixteen Horner accumulators run side by side, one per syndrome. Each one multiplies by its own fixed power of alpha through a constant-coefficient XOR network. The symbol that arrives first is the highest-degree coefficient. A block ends on the valid symbol that carries the last marker, so shortened codewords are simply fed with fewer symbols, and the missing leading zeros are implied.

When a block ends, the finished syndromes are copied into an output register and a one-cycle done pulse is raised. A flag reports that every syndrome is zero, so that later decoding stages can be bypassed. The next codeword may start on the very next clock.

Top module: `rs_syndrome`

## Requirements
- R1: While reset is asserted and after it is released, before any block has ended, `syn_flat` is all zero and both `syn_done` and `syn_clean` are low.
- R2: For a block r1..rL (r1 first), byte i of `syn_flat` (bits 8i+7:8i) equals the sum of r_k times alpha^(i*(L-k)). Arithmetic is in GF(2^8) with reduction polynomial 0x11D, and alpha = 0x02.
- R3: The first valid symbol after reset, or after a symbol accepted with `sym_last`, starts a new block. Nothing from an earlier block enters its result.
- R4: `syn_done` is high for exactly the one cycle that follows each clock edge at which `sym_vld` and `sym_last` are both high. It is low at every other time.
- R5: `syn_flat` and `syn_clean` change only in a cycle where `syn_done` is high. Otherwise they hold their values.
- R6: `syn_clean` is high together with `syn_done` exactly when all syndromes of the finished block are zero. A multiple of the generator polynomial with roots alpha^0..alpha^15 therefore reports clean, while the same word with one corrupted symbol does not.
- R7: Blocks may follow each other with no idle cycle. Each of them yields its own correct syndromes and its own done pulse.
- R8: Cycles with `sym_vld` low do not change the accumulation, and `sym_last` has no effect in those cycles.
- R9: Shortened blocks give correct results. For a one-symbol block every syndrome equals r1. For a two-symbol block Si = r1*alpha^i + r2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_vld | input | 1 | Symbol on `sym_in` is valid this cycle |
| sym_last | input | 1 | With `sym_vld`, marks the final symbol of a block |
| sym_in | input | 8 | Received symbol, highest-degree coefficient first |
| syn_flat | output | 128 | Syndromes; Si in bits 8i+7:8i |
| syn_done | output | 1 | One-cycle pulse: a new syndrome set is on `syn_flat` |
| syn_clean | output | 1 | All syndromes of the last finished block are zero |

## Verification
Two events can fall in the same cycle. The cycle in which a finished block is presented with its done pulse is the cycle in which the first symbol of the next block is loaded into the accumulators. When a one-symbol block ends a block and starts one at once, the two events also meet inside a single symbol. The bench provokes both by sending codewords back to back with no gap, including runs of 256 one-symbol and 256 two-symbol blocks that sweep every byte value. Each done pulse is matched in order against syndromes computed in the bench by direct power-sum evaluation. In every other cycle the bench confirms that the presented values stay unchanged.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  localparam int unsigned SYM_W = 8;
  // low byte of x^8+x^4+x^3+x^2+1
  localparam logic [SYM_W-1:0] RED_POLY = 8'h1D;

  // generic field product; with a constant operand it folds into XOR gates
  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] prod;
    logic [SYM_W-1:0] sh;
    prod = '0;
    sh   = a;
    for (int k = 0; k < int'(SYM_W); k++) begin
      if (b[k]) prod = prod ^ sh;
      sh = sh[SYM_W-1] ? ({sh[SYM_W-2:0], 1'b0} ^ RED_POLY)
                       : {sh[SYM_W-2:0], 1'b0};
    end
    return prod;
  endfunction

  function automatic logic [SYM_W-1:0] gf_alpha_pow(input int unsigned e);
    logic [SYM_W-1:0] r;
    r = SYM_W'(1);
    for (int unsigned k = 0; k < e; k++) r = gf_mul(r, SYM_W'(2));
    return r;
  endfunction

endpackage

// File: rtl/rs_syn_cmul.sv
module rs_syn_cmul
  import rs_syn_pkg::*;
#(
  parameter logic [SYM_W-1:0] COEF = 8'h01
) (
  input  logic [SYM_W-1:0] din,
  output logic [SYM_W-1:0] dout
);

  logic [SYM_W-1:0] part [SYM_W];

  // one precomputed column per input bit: COEF * x^j
  for (genvar j = 0; j < int'(SYM_W); j++) begin : g_col
    localparam logic [SYM_W-1:0] COL = gf_mul(COEF, SYM_W'(1) << j);
    assign part[j] = din[j] ? COL : '0;
  end

  always_comb begin
    dout = '0;
    for (int j = 0; j < int'(SYM_W); j++) dout = dout ^ part[j];
  end

endmodule

// File: rtl/rs_syn_frame.sv
module rs_syn_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_vld,
  input  logic sym_last,
  output logic blk_first
);

  logic open_q;
  logic open_d;

  always_comb begin
    open_d = open_q;
    if (sym_vld) open_d = ~sym_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign blk_first = ~open_q;

  // a block ends -> the next valid symbol must be treated as the first one
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld && sym_last |=> blk_first);

  // idle cycles do not open or close a block, whatever sym_last says
  p_idle_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> $stable(blk_first));

endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_syn_pkg::*;
#(
  parameter int unsigned ROOT_EXP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_vld,
  input  logic             blk_first,
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] acc_nxt
);

  localparam logic [SYM_W-1:0] ROOT = gf_alpha_pow(ROOT_EXP % 255);

  logic [SYM_W-1:0] acc_q;
  logic [SYM_W-1:0] scaled;

  rs_syn_cmul #(.COEF(ROOT)) u_mul (
    .din  (acc_q),
    .dout (scaled)
  );

  // Horner step; the first symbol of a block replaces the old value
  always_comb begin
    if (blk_first) acc_nxt = sym_in;
    else           acc_nxt = scaled ^ sym_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (sym_vld) acc_q <= acc_nxt;
  end

  p_fresh_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld && blk_first |=> acc_q == $past(sym_in));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> $stable(acc_q));

endmodule

// File: rtl/rs_syn_out.sv
module rs_syn_out
  import rs_syn_pkg::*;
#(
  parameter int unsigned NUM_SYN = 16,
  localparam int unsigned VEC_W = NUM_SYN * SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [VEC_W-1:0] syn_nxt,
  output logic [VEC_W-1:0] syn_q,
  output logic             done_q,
  output logic             clean_q
);

  logic clean_d;

  always_comb clean_d = (syn_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q   <= '0;
      done_q  <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      done_q <= cap_en;
      if (cap_en) begin
        syn_q   <= syn_nxt;
        clean_q <= clean_d;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(syn_q) && $stable(clean_q));

  p_clean_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clean_q |-> syn_q == '0);

  p_done_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> done_q);

endmodule

// File: rtl/rs_syndrome.sv
module rs_syndrome
  import rs_syn_pkg::*;
#(
  parameter int unsigned NUM_SYN    = 16,
  parameter int unsigned FIRST_ROOT = 0,
  localparam int unsigned VEC_W = NUM_SYN * SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_vld,
  input  logic             sym_last,
  input  logic [SYM_W-1:0] sym_in,
  output logic [VEC_W-1:0] syn_flat,
  output logic             syn_done,
  output logic             syn_clean
);

  logic             blk_first;
  logic             cap_en;
  logic [VEC_W-1:0] syn_nxt;

  rs_syn_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_vld   (sym_vld),
    .sym_last  (sym_last),
    .blk_first (blk_first)
  );

  for (genvar i = 0; i < int'(NUM_SYN); i++) begin : g_cell
    rs_syn_cell #(.ROOT_EXP(FIRST_ROOT + i)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .sym_vld   (sym_vld),
      .blk_first (blk_first),
      .sym_in    (sym_in),
      .acc_nxt   (syn_nxt[i*SYM_W +: SYM_W])
    );
  end

  assign cap_en = sym_vld & sym_last;

  rs_syn_out #(.NUM_SYN(NUM_SYN)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .syn_nxt (syn_nxt),
    .syn_q   (syn_flat),
    .done_q  (syn_done),
    .clean_q (syn_clean)
  );

  p_no_spurious_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_vld && sym_last) |=> !syn_done);

endmodule

// File: tb/rs_syndrome_bench.sv
module rs_syndrome_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sym_vld = 1'b0;
  logic         sym_last = 1'b0;
  logic [7:0]   sym_in = 8'h00;
  logic [127:0] syn_flat;
  logic         syn_done;
  logic         syn_clean;

  always #5 clk = ~clk;

  rs_syndrome u_rs_syndrome (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_vld   (sym_vld),
    .sym_last  (sym_last),
    .sym_in    (sym_in),
    .syn_flat  (syn_flat),
    .syn_done  (syn_done),
    .syn_clean (syn_clean)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit mon_on = 0;

  logic [7:0]   pow_tab [255];
  logic [7:0]   blk [255];
  logic [127:0] exp_q [$];
  string        tag_q [$];
  logic [127:0] held_syn = '0;
  logic         held_clean = 1'b0;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int k = 0; k < 8; k++) if (b[k]) p = p ^ (16'(a) << k);
    for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011D << (k - 8));
    return p[7:0];
  endfunction

  // direct evaluation: S_i = sum r_k * alpha^(i*(L-1-k)), k counted from 0
  function automatic logic [127:0] ref_syn(input int len);
    logic [127:0] v = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] s = 8'h00;
      for (int k = 0; k < len; k++)
        s = s ^ gmul(blk[k], pow_tab[(i * (len - 1 - k)) % 255]);
      v[i*8 +: 8] = s;
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] s, input logic l);
    @(negedge clk);
    sym_vld = 1'b1; sym_in = s; sym_last = l;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      sym_vld = 1'b0; sym_in = 8'($urandom); sym_last = 1'($urandom);
    end
  endtask

  // sends blk[0..len-1]; gaps>0 inserts random idle cycles inside the block
  task automatic send_block(input string tag, input int len, input int gaps);
    for (int k = 0; k < len; k++) begin
      if (gaps > 0 && ($urandom % 3) == 0) idle(1 + $urandom % gaps);
      if (k == len - 1) begin
        exp_q.push_back(ref_syn(len));
        tag_q.push_back(tag);
      end
      put(blk[k], k == len - 1);
    end
  endtask

  // monitor: every done is matched in order, every other cycle must hold
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (syn_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected done", 128'(syn_done), 128'd0);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(syn_flat == e, t, syn_flat, e);
          check(syn_clean == (e == '0), "R6 clean flag",
                128'(syn_clean), 128'(e == '0));
        end
        held_syn   = syn_flat;
        held_clean = syn_clean;
      end else begin
        check(syn_flat == held_syn && syn_clean == held_clean, "R5 hold",
              {syn_flat[126:0], syn_clean}, {held_syn[126:0], held_clean});
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] g [17];
    logic [7:0] m [239];
    logic [7:0] c [255];

    pow_tab[0] = 8'h01;
    for (int e = 1; e < 255; e++) pow_tab[e] = gmul(pow_tab[e-1], 8'h02);

    // R1: outputs during and after reset
    repeat (3) @(negedge clk);
    check(syn_flat == '0 && !syn_done && !syn_clean, "R1 in reset",
          syn_flat, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(syn_flat == '0 && !syn_done && !syn_clean, "R1 after release",
          {syn_flat[125:0], syn_done, syn_clean}, 128'd0);
    mon_on = 1;

    // R2: full-length random block, no gaps
    for (int k = 0; k < 255; k++) blk[k] = 8'($urandom);
    send_block("R2 full random", 255, 0);
    idle(2);

    // R8: random block with idle cycles carrying junk and sym_last
    for (int k = 0; k < 255; k++) blk[k] = 8'($urandom);
    send_block("R8 gaps ignored", 255, 3);

    // R6/R7: a valid codeword, then the corrupted word, back to back
    for (int j = 0; j < 17; j++) g[j] = 8'h00;
    g[0] = 8'h01;
    for (int i = 0; i < 16; i++)
      for (int j = i + 1; j >= 0; j--)
        g[j] = (j > 0 ? g[j-1] : 8'h00) ^ gmul(g[j], pow_tab[i]);
    for (int a = 0; a < 239; a++) m[a] = 8'($urandom);
    for (int j = 0; j < 255; j++) c[j] = 8'h00;
    for (int a = 0; a < 239; a++)
      for (int b = 0; b < 17; b++) c[a+b] = c[a+b] ^ gmul(m[a], g[b]);
    for (int k = 0; k < 255; k++) blk[k] = c[254-k];
    send_block("R6 codeword clean", 255, 0);
    blk[100] = blk[100] ^ 8'h01;
    send_block("R7 corrupted word back to back", 255, 0);

    // R6: all-zero shortened block
    for (int k = 0; k < 40; k++) blk[k] = 8'h00;
    send_block("R6 zero block", 40, 0);

    // R9/R7: every byte value as a one-symbol block, consecutive
    for (int v = 0; v < 256; v++) begin
      blk[0] = 8'(v);
      send_block("R9 single symbol", 1, 0);
    end

    // R9/R3: every byte value as r1 of a two-symbol block, consecutive
    for (int v = 0; v < 256; v++) begin
      blk[0] = 8'(v);
      blk[1] = 8'(255 - v);
      send_block("R9 two symbols", 2, 0);
    end
    idle(3);

    // R9: shortened block with gaps
    for (int k = 0; k < 10; k++) blk[k] = 8'($urandom);
    send_block("R9 shortened with gaps", 10, 2);

    // R3: block right after a nonzero block starts fresh
    for (int k = 0; k < 5; k++) blk[k] = 8'h00;
    send_block("R3 fresh start", 5, 0);
    idle(6);

    check(exp_q.size() == 0, "R4 missing done", 128'(exp_q.size()), 128'd0);
    summary();
  end

endmodule